// File: doc/BRIEF.md
# Pseudo-Random Loopback Self-Test Engine

This block runs a built-in self test over a loopback path. When software raises its start control, the block emits a serial pseudo-random bit stream, one bit per cycle, marked by a valid strobe. The stream leaves the block, passes through a loopback path of unknown latency, and comes back on a receive port with its own valid strobe. A checker inside the block locks onto the returned stream and predicts each following bit. Any mismatch sets a sticky fail flag.

A select input picks one of two sequence lengths: a 15-stage sequence or a 9-stage sequence. The checker needs no alignment with the generator. It fills its history register from the first bits that arrive and from then on compares every bit against its own prediction.

The test ends after a window of checked bits, and the block then reports done, with pass or fail. A new rise of the start control clears the result and begins again. Lowering the start control stops the test and freezes the status.

Top module: `prbs_bist`

## Requirements
- R1: While reset is asserted and after it is released, `tx_valid_o`, `done_o`, `fail_o` and `pass_o` are low.
- R2: On a rising edge of `start_i`, `done_o` and `fail_o` are cleared at the next clock edge, and `tx_valid_o` goes high from that same edge.
- R3: The value of `seq_long_i` at the start rise fixes the sequence. A value of 1 makes the emitted bits obey b[k] = b[k-15] XOR b[k-14]. A value of 0 makes them obey b[k] = b[k-9] XOR b[k-5]. Changes to `seq_long_i` during a run have no effect.
- R4: The first L valid received bits after a start rise only load the checker history and are never compared, where L is 15 or 9 for the selected sequence. A corrupted bit among them still leads to a fail, because later predictions are built from it.
- R5: A received bit at valid index L to L+W-1 that differs from the prediction made from the preceding received bits sets `fail_o`. Here W is `WIN_BITS` and indexes count from 0 after the start rise. `fail_o` then stays high until the next start rise.
- R6: After W compared bits, `done_o` rises and stays high until the next start rise. `tx_valid_o` is then low, and received bits arriving later have no effect. `pass_o` is high exactly when `done_o` is high and `fail_o` is low.
- R7: When `start_i` falls, `tx_valid_o` is low from the next clock edge, and `done_o` and `fail_o` keep their values.
- R8: Received bits are consumed only in cycles where `rx_valid_i` is high. Gaps in the returned stream change nothing.
- R9: A returned stream that follows the other sequence's recurrence, not the selected one, yields a fail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Test control bit: a rise starts a run, a fall stops it |
| seq_long_i | input | 1 | Sequence select: 1 = 15-stage, 0 = 9-stage |
| tx_bit_o | output | 1 | Generated serial bit |
| tx_valid_o | output | 1 | High when tx_bit_o carries a sequence bit |
| rx_bit_i | input | 1 | Bit returned by the loopback path |
| rx_valid_i | input | 1 | High when rx_bit_i carries a returned bit |
| done_o | output | 1 | Test window completed (latched) |
| fail_o | output | 1 | Mismatch seen during the run (latched) |
| pass_o | output | 1 | Window completed without mismatch |

## Verification
The assertions assume that `start_i` changes only between clock edges and is a level held by software. They assume no start rise is expected to take effect during reset. They also assume that the received valid strobe stays low except for bits actually sent by this run. The stimulus holds `start_i` low for many cycles between runs, and it flushes the loopback stub on every start. Bits left over from an earlier run therefore reach the block only while it is stopped or inside the restart cycle, where they are discarded. Every start rise is preceded by a low phase, so each rise is a clean edge.

// File: rtl/prbs_bist_pkg.sv
package prbs_bist_pkg;

    localparam int unsigned HIST_W    = 15;
    localparam int unsigned LONG_LEN  = 15;
    localparam int unsigned SHORT_LEN = 9;
    localparam int unsigned LONG_TAP_A  = 14;
    localparam int unsigned LONG_TAP_B  = 13;
    localparam int unsigned SHORT_TAP_A = 8;
    localparam int unsigned SHORT_TAP_B = 4;
    localparam int unsigned LEN_W     = 4;

    typedef logic [HIST_W-1:0] hist_t;

    // Next bit of the selected recurrence; h[0] is the newest bit.
    function automatic logic prbs_next(input hist_t h, input logic long_sel);
        logic b;
        if (long_sel) b = h[LONG_TAP_A] ^ h[LONG_TAP_B];
        else          b = h[SHORT_TAP_A] ^ h[SHORT_TAP_B];
        return b;
    endfunction

    function automatic logic [LEN_W-1:0] seq_len(input logic long_sel);
        return long_sel ? LEN_W'(LONG_LEN) : LEN_W'(SHORT_LEN);
    endfunction

endpackage

// File: rtl/prbs_bist_ctrl.sv
module prbs_bist_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic seq_long_i,
    output logic restart_o,
    output logic run_o,
    output logic long_o
);

    typedef struct packed {
        logic start_seen;
        logic run;
        logic long_sel;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  rise;

    always_comb begin
        ctl_d            = ctl_q;
        rise             = start_i && !ctl_q.start_seen;
        ctl_d.start_seen = start_i;
        if (rise) begin
            ctl_d.run      = 1'b1;
            ctl_d.long_sel = seq_long_i;
        end else if (!start_i) begin
            ctl_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    assign restart_o = rise;
    assign run_o     = ctl_q.run;
    assign long_o    = ctl_q.long_sel;

endmodule

// File: rtl/prbs_bist_gen.sv
module prbs_bist_gen
    import prbs_bist_pkg::*;
#(
    parameter hist_t SEED = '1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic shift_i,
    input  logic long_i,
    output logic bit_o
);

    hist_t hist_d, hist_q;
    logic  nxt;

    always_comb begin
        hist_d = hist_q;
        nxt    = prbs_next(hist_q, long_i);
        if (restart_i)    hist_d = SEED;
        else if (shift_i) hist_d = {hist_q[HIST_W-2:0], nxt};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= SEED;
        else         hist_q <= hist_d;
    end

    assign bit_o = nxt;

endmodule

// File: rtl/prbs_bist_chk.sv
module prbs_bist_chk
    import prbs_bist_pkg::*;
#(
    parameter int unsigned WIN_BITS = 64
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic run_i,
    input  logic long_i,
    input  logic rx_valid_i,
    input  logic rx_bit_i,
    output logic done_o,
    output logic fail_o
);

    localparam int unsigned CNT_W = $clog2(WIN_BITS + 1);

    typedef struct packed {
        logic [LEN_W-1:0] sync_cnt;
        hist_t            hist;
        logic [CNT_W-1:0] chk_cnt;
        logic             done;
        logic             fail;
    } chk_t;

    chk_t chk_d, chk_q;
    logic take;
    logic synced;
    logic predicted;

    always_comb begin
        chk_d     = chk_q;
        take      = run_i && !chk_q.done && rx_valid_i;
        synced    = (chk_q.sync_cnt == seq_len(long_i));
        predicted = prbs_next(chk_q.hist, long_i);
        if (restart_i) begin
            chk_d = '0;
        end else if (take) begin
            if (!synced) begin
                chk_d.sync_cnt = chk_q.sync_cnt + 1'b1;
            end else begin
                if (predicted != rx_bit_i) chk_d.fail = 1'b1;
                chk_d.chk_cnt = chk_q.chk_cnt + 1'b1;
                if (chk_q.chk_cnt == CNT_W'(WIN_BITS - 1)) chk_d.done = 1'b1;
            end
            chk_d.hist = {chk_q.hist[HIST_W-2:0], rx_bit_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chk_q <= '0;
        else         chk_q <= chk_d;
    end

    assign done_o = chk_q.done;
    assign fail_o = chk_q.fail;

endmodule

// File: rtl/prbs_bist.sv
module prbs_bist
    import prbs_bist_pkg::*;
#(
    parameter int unsigned WIN_BITS = 64,
    parameter hist_t       SEED     = '1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic seq_long_i,
    output logic tx_bit_o,
    output logic tx_valid_o,
    input  logic rx_bit_i,
    input  logic rx_valid_i,
    output logic done_o,
    output logic fail_o,
    output logic pass_o
);

    logic restart;
    logic run;
    logic long_sel;
    logic done;
    logic fail;
    logic emit;

    prbs_bist_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .seq_long_i(seq_long_i),
        .restart_o (restart),
        .run_o     (run),
        .long_o    (long_sel)
    );

    assign emit = run && !done;

    prbs_bist_gen #(.SEED(SEED)) u_gen (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .restart_i(restart),
        .shift_i  (emit),
        .long_i   (long_sel),
        .bit_o    (tx_bit_o)
    );

    prbs_bist_chk #(.WIN_BITS(WIN_BITS)) u_chk (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .run_i     (run),
        .long_i    (long_sel),
        .rx_valid_i(rx_valid_i),
        .rx_bit_i  (rx_bit_i),
        .done_o    (done),
        .fail_o    (fail)
    );

    assign tx_valid_o = emit;
    assign done_o     = done;
    assign fail_o     = fail;
    assign pass_o     = done && !fail;

endmodule

// File: rtl/prbs_bist_sva.sv
module prbs_bist_sva (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic tx_valid_o,
    input logic done_o,
    input logic fail_o
);

    p_reset_quiet_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!tx_valid_o && !done_o && !fail_o));

    p_restart_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(start_i) |=> (!done_o && !fail_o && tx_valid_o));

    p_fail_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fail_o && !$rose(start_i)) |=> fail_o);

    p_done_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !$rose(start_i)) |=> done_o);

    p_quiet_after_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !tx_valid_o);

    p_stop_halts_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> !tx_valid_o);

    p_stop_holds_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!start_i && !$past(start_i)) |=> ($stable(fail_o) && $stable(done_o)));

endmodule

bind prbs_bist prbs_bist_sva u_sva (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .tx_valid_o(tx_valid_o),
    .done_o    (done_o),
    .fail_o    (fail_o)
);

// File: tb/prbs_bist_tb.sv
module prbs_bist_tb;

    localparam int WIN = 64;
    localparam int LAT = 5;
    localparam int HMAX = 1024;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic start_i = 1'b0;
    logic seq_long_i = 1'b0;
    logic tx_bit_o, tx_valid_o;
    logic rx_bit_i = 1'b1;
    logic rx_valid_i = 1'b0;
    logic done_o, fail_o, pass_o;

    always #2 clk = ~clk;

    prbs_bist #(.WIN_BITS(WIN)) u_dut (
        .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .seq_long_i(seq_long_i),
        .tx_bit_o(tx_bit_o), .tx_valid_o(tx_valid_o),
        .rx_bit_i(rx_bit_i), .rx_valid_i(rx_valid_i),
        .done_o(done_o), .fail_o(fail_o), .pass_o(pass_o)
    );

    int n_checks = 0;
    int n_fails  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // loopback stub state
    bit  lq[$];
    int  lt[$];
    int  cyc = 0;
    int  push_n = 0;
    int  inj_idx = -1;
    bit  foreign = 0;
    bit  gaps = 0;
    logic [14:0] h9 = 15'h01ff;

    always @(posedge clk) begin
        bit b;
        cyc++;
        if (tx_valid_o) begin
            if (foreign) begin
                b  = h9[8] ^ h9[4];
                h9 = {h9[13:0], b};
            end else begin
                b = tx_bit_o;
            end
            if (push_n == inj_idx) b = ~b;
            lq.push_back(b);
            lt.push_back(cyc);
            push_n++;
        end
        if (lq.size() > 0 && cyc >= lt[0] + LAT && !(gaps && (cyc % 3 == 0))) begin
            rx_valid_i <= 1'b1;
            rx_bit_i   <= lq.pop_front();
            void'(lt.pop_front());
        end else begin
            rx_valid_i <= 1'b0;
            rx_bit_i   <= ~rx_bit_i;
        end
    end

    // transmit recurrence monitor
    bit txh[HMAX];
    int tx_n = 0;
    int tx_err = 0;
    bit mon_long = 1;

    always @(negedge clk) begin
        if (rst_ni && tx_valid_o && tx_n < HMAX) begin
            bit e;
            if (mon_long && tx_n >= 15) begin
                e = txh[tx_n-15] ^ txh[tx_n-14];
                if (e != tx_bit_o) tx_err++;
            end else if (!mon_long && tx_n >= 9) begin
                e = txh[tx_n-9] ^ txh[tx_n-5];
                if (e != tx_bit_o) tx_err++;
            end
            txh[tx_n] = tx_bit_o;
            tx_n++;
        end
    end

    // scoreboard: expected result per run, popped when done rises
    bit    exp_q[$];
    string req_q[$];
    bit    done_seen = 0;

    always @(negedge clk) begin
        if (rst_ni && done_o && !done_seen) begin
            done_seen = 1;
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected done", 1, 0);
            end else begin
                bit    e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(fail_o == e, r, fail_o, e);
                check(pass_o == !e, "R6 pass flag", pass_o, !e);
            end
        end else if (!done_o) begin
            done_seen = 0;
        end
    end

    task automatic begin_run(input bit lng, input bit frn, input bit gp, input int inj);
        @(negedge clk);
        lq.delete(); lt.delete();
        push_n = 0; inj_idx = inj; foreign = frn; gaps = gp; h9 = 15'h01ff;
        tx_n = 0; tx_err = 0; mon_long = lng;
        seq_long_i = lng;
        start_i = 1'b1;
        @(negedge clk);
        check(!done_o && !fail_o && tx_valid_o, "R2 start clears and emits",
              {done_o, fail_o, tx_valid_o}, 3'b001);
    endtask

    task automatic run_test(input bit lng, input bit frn, input bit gp, input int inj,
                            input bit efail, input bit toggle, input string req);
        int k;
        exp_q.push_back(efail);
        req_q.push_back(req);
        begin_run(lng, frn, gp, inj);
        if (toggle) seq_long_i = ~lng;
        k = 0;
        while (exp_q.size() != 0 && k < 3000) begin
            @(negedge clk);
            k++;
        end
        if (exp_q.size() != 0) begin
            check(0, {req, " no done"}, 0, 1);
            exp_q.delete(); req_q.delete();
        end
        @(negedge clk);
        check(!tx_valid_o, "R6 tx idle after done", tx_valid_o, 0);
        check(tx_err == 0 && tx_n > (lng ? 15 : 9), "R3 emitted recurrence", tx_err, 0);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        int wd;
        wd = 0;
        fork
            begin
                repeat (4) @(negedge clk);
                check(!tx_valid_o && !done_o && !fail_o && !pass_o, "R1 reset state",
                      {tx_valid_o, done_o, fail_o, pass_o}, 0);
                rst_ni = 1'b1;
                repeat (3) @(negedge clk);
                check(!tx_valid_o && !done_o && !fail_o, "R1 idle after reset",
                      {tx_valid_o, done_o, fail_o}, 0);

                run_test(1, 0, 0, -1, 0, 0, "R6 long clean pass");
                run_test(0, 0, 0, -1, 0, 0, "R6 short clean pass");
                run_test(1, 0, 0, 15 + 10, 1, 0, "R5 long mid-window error");
                run_test(0, 0, 0, 9 + WIN - 1, 1, 0, "R5 short last-window-bit error");
                run_test(1, 0, 0, 15 + WIN, 0, 0, "R6 error after window ignored");
                run_test(1, 0, 0, 3, 1, 0, "R4 error during sync bits");
                run_test(1, 0, 1, -1, 0, 0, "R8 gapped return clean pass");
                run_test(0, 0, 1, 9 + 20, 1, 0, "R8 gapped return with error");
                run_test(1, 1, 0, -1, 1, 0, "R9 other-length stream fails");
                run_test(0, 0, 0, -1, 0, 1, "R3 select change mid-run ignored");

                // R7: stop after an error, status held
                begin_run(1, 0, 0, 20);
                wd = 0;
                while (!fail_o && wd < 500) begin @(negedge clk); wd++; end
                check(fail_o, "R5 fail seen before stop", fail_o, 1);
                start_i = 1'b0;
                @(negedge clk);
                check(!tx_valid_o, "R7 tx stops next edge", tx_valid_o, 0);
                repeat (100) @(negedge clk);
                check(fail_o && !done_o, "R7 status held after stop", {done_o, fail_o}, 2'b01);

                // R7: stop a clean run, nothing completes
                begin_run(0, 0, 0, -1);
                repeat (10) @(negedge clk);
                start_i = 1'b0;
                repeat (100) @(negedge clk);
                check(!fail_o && !done_o && !tx_valid_o, "R7 clean stop holds idle",
                      {tx_valid_o, done_o, fail_o}, 0);

                // R2: restart after fail clears result
                run_test(1, 0, 0, 15 + 5, 1, 0, "R5 fail before restart");
                run_test(1, 0, 0, -1, 0, 0, "R2 restart yields pass");
            end
            begin
                repeat (150000) @(negedge clk);
                check(0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule